// File: doc/BRIEF.md
# One-Shot Cycle Interrupt Timer

This block is a 15-bit down-counting interrupt timer for an 8-bit CPU bus. Software programs it through two byte-wide write strobes.

- A write to the low strobe only parks a byte in a holding register.
- A write to the high strobe commits a 15-bit start value made of its own low seven bits and the parked byte. Its top bit switches counting on or off, and the same write releases any pending interrupt.

While counting is enabled, the count drops by one on every clock edge at which the CPU-cycle enable is high. When the count reaches zero, the block pulls its active-low interrupt output low, switches itself off and stops. The interrupt stays low until the next high-strobe write or a reset.

A typical use is a raster or delay timer. Software writes the low byte, then writes the high byte with the top bit set, and services the interrupt after exactly that many CPU cycles. In the service routine, a second high write both acknowledges the interrupt and optionally re-arms the timer.

Top module: `cyc_irq_timer`

## Requirements
- R1: A low-strobe write (`wr_lo`) stores `wr_data` in the holding register and changes neither the count, the enable nor `irq_n`.
- R2: A high-strobe write (`wr_hi`) loads the count with {`wr_data[6:0]`, held byte}. With enable set and that value N nonzero, `irq_n` goes low on the edge that carries the N-th counted cycle after the write edge.
- R3: Bit 7 of the high-strobe data is the enable. With bit 7 at 0 the loaded count never decrements and no interrupt follows, and this also holds when a running count is overwritten.
- R4: Any high-strobe write drives `irq_n` to 1 on its edge, whatever the data.
- R5: The count decrements only on edges where `cyc_en` is 1. Edges with `cyc_en` at 0 leave it unchanged.
- R6: On reaching zero the block drives `irq_n` to 0, clears its enable and stops counting.
- R7: A high-strobe write that loads zero with bit 7 set never produces an interrupt.
- R8: Once low, `irq_n` stays low until a high-strobe write or a reset, regardless of `cyc_en` and `wr_lo`.
- R9: Asserting `rst_n` low immediately drives `irq_n` to 1. It also clears the count, the enable and the holding register. Its release takes effect after two clock edges.
- R10: A high-strobe write takes priority over counting on the same edge, and that edge's `cyc_en` is not counted. When `wr_lo` and `wr_hi` occur together, the load uses the previously held byte and the new byte is held afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_en | input | 1 | One-cycle enable marking a CPU cycle to be counted |
| wr_lo | input | 1 | Low-byte write strobe |
| wr_hi | input | 1 | High-byte write strobe (load, enable, acknowledge) |
| wr_data | input | 8 | Write data for both strobes |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Every strobe takes effect on the edge that samples it. The acknowledge shows up right after the high-write edge. The interrupt falls right after the edge carrying the N-th counted `cyc_en` that follows the write edge. The bench drives inputs on the falling edge and samples `irq_n` one nanosecond after each rising edge. It keeps its own count of enabled cycles since the load, so on every cycle it expects `irq_n` low exactly when that count has reached N. The asynchronous reset effect is checked one nanosecond after `rst_n` falls, before any clock edge.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;
  localparam int BYTE_W  = 8;
  localparam int COUNT_W = 2 * BYTE_W - 1;
  localparam int HI_BITS = COUNT_W - BYTE_W;
  localparam int EN_BIT  = BYTE_W - 1;

  typedef logic [BYTE_W-1:0]  byte_t;
  typedef logic [COUNT_W-1:0] count_t;

  // Start value from the committing high byte and the parked low byte
  function automatic count_t join_load(input byte_t hi, input byte_t lo);
    return {hi[HI_BITS-1:0], lo};
  endfunction
endpackage

// File: rtl/cyc_irq_rst_sync.sv
module cyc_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/cyc_irq_lo_hold.sv
module cyc_irq_lo_hold
  import cyc_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_lo,
  input  byte_t wr_data,
  output byte_t hold_q
);
  byte_t hold_d;

  always_comb begin
    hold_d = hold_q;
    if (wr_lo) hold_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end
endmodule

// File: rtl/cyc_irq_counter.sv
module cyc_irq_counter
  import cyc_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cyc_en,
  input  logic   load,
  input  count_t load_val,
  input  logic   load_en,
  output count_t cnt_q,
  output logic   en_q,
  output logic   expire
);
  count_t cnt_d;
  logic   en_d;
  logic   step;

  // A load on the same edge overrides counting
  assign step   = !load && en_q && cyc_en && (cnt_q != '0);
  assign expire = step && (cnt_q == count_t'(1));

  always_comb begin
    cnt_d = cnt_q;
    en_d  = en_q;
    if (load) begin
      cnt_d = load_val;
      en_d  = load_en;
    end else if (step) begin
      cnt_d = cnt_q - count_t'(1);
      if (expire) en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cyc_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              irq_n
);
  logic   rst_n_s;
  byte_t  hold_q;
  count_t cnt_q;
  logic   en_q;
  logic   expire;
  logic   irq_n_q;
  logic   irq_n_d;

  cyc_irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  cyc_irq_lo_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_lo   (wr_lo),
    .wr_data (wr_data),
    .hold_q  (hold_q)
  );

  cyc_irq_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cyc_en   (cyc_en),
    .load     (wr_hi),
    .load_val (join_load(wr_data, hold_q)),
    .load_en  (wr_data[EN_BIT]),
    .cnt_q    (cnt_q),
    .en_q     (en_q),
    .expire   (expire)
  );

  // High write acknowledges; expiry pulls the line low and it then holds
  always_comb begin
    irq_n_d = irq_n_q;
    if (wr_hi)       irq_n_d = 1'b1;
    else if (expire) irq_n_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) irq_n_q <= 1'b1;
    else          irq_n_q <= irq_n_d;
  end

  assign irq_n = irq_n_q;
endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk
  import cyc_irq_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   cyc_en,
  input logic   wr_lo,
  input logic   wr_hi,
  input byte_t  wr_data,
  input byte_t  hold_q,
  input count_t cnt_q,
  input logic   en_q,
  input logic   irq_n
);
  a_r1_lo_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi && !(en_q && cyc_en)) |=> $stable(cnt_q));

  a_r2_hi_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (cnt_q == {$past(wr_data[HI_BITS-1:0]), $past(hold_q)}));

  a_r3_enable_bit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (en_q == $past(wr_data[EN_BIT])));

  a_r4_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> irq_n);

  a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi && !cyc_en) |=> $stable(cnt_q));

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi && en_q && cyc_en && cnt_q != '0) |=> (cnt_q == count_t'($past(cnt_q) - 1'b1)));

  a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> (cnt_q == '0 && !en_q));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !wr_hi) |=> !irq_n);
endmodule

bind cyc_irq_timer cyc_irq_timer_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .cyc_en  (cyc_en),
  .wr_lo   (wr_lo),
  .wr_hi   (wr_hi),
  .wr_data (wr_data),
  .hold_q  (hold_q),
  .cnt_q   (cnt_q),
  .en_q    (en_q),
  .irq_n   (irq_n)
);

// File: tb/cyc_irq_timer_bench.sv
`timescale 1ns/1ps
module cyc_irq_timer_bench;
  logic       clk;
  logic       rst_n;
  logic       cyc_en;
  logic       wr_lo;
  logic       wr_hi;
  logic [7:0] wr_data;
  logic       irq_n;

  int n_run;
  int n_fail;
  int cyc_cnt;
  logic [7:0] held;

  cyc_irq_timer u_cyc_irq_timer (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .wr_data(wr_data), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  initial begin
    #(5.0 * 180000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic int start_val(input logic [7:0] hi, input logic [7:0] lo);
    return int'({hi[6:0], lo});
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_n actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc_cnt);
    end
  endtask

  task automatic drive(input logic lo, input logic hi, input logic tick, input logic [7:0] d);
    @(negedge clk);
    wr_lo = lo; wr_hi = hi; cyc_en = tick; wr_data = d;
    @(posedge clk);
    #1;
    if (lo) held = d;
  endtask

  // Run ticks with given percentage; expect the fall exactly at the n-th counted cycle
  task automatic run_fire(input int n, input int pct, input string tag);
    int ticks = 0;
    while (ticks < n) begin
      logic t;
      t = (($urandom % 100) < pct) || (pct >= 100);
      drive(0, 0, t, 8'h00);
      if (t) ticks++;
      check(irq_n, (ticks >= n) ? 1'b0 : 1'b1, tag);
    end
    for (int k = 0; k < 3; k++) begin
      drive(0, 0, 1'b1, 8'h00);
      check(irq_n, 1'b0, "R8 stays low");
    end
  endtask

  task automatic run_quiet(input int cycles, input string tag);
    for (int k = 0; k < cycles; k++) begin
      drive(0, 0, 1'b1, 8'h00);
      check(irq_n, 1'b1, tag);
    end
  endtask

  task automatic load(input logic [7:0] lo, input logic [7:0] hi);
    drive(1, 0, 1, lo);
    drive(0, 1, 1, hi); // R10: tick on the write edge is not counted
    check(irq_n, 1'b1, "R4 ack on high write");
  endtask

  initial begin
    void'($urandom(32'd1234));
    n_run = 0; n_fail = 0; cyc_cnt = 0; held = 8'h00;
    rst_n = 1'b0; cyc_en = 0; wr_lo = 0; wr_hi = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    #1;
    check(irq_n, 1'b1, "R9 reset state");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: low write alone starts nothing
    drive(1, 0, 1, 8'h05);
    run_quiet(40, "R1 low write only");

    // R2: basic count of 5
    drive(0, 1, 1, 8'h80);
    check(irq_n, 1'b1, "R4 ack");
    run_fire(start_val(8'h80, held), 100, "R2 fire at 5");

    // R8 sticky, then R4 ack with disabled load, R3 no fire
    for (int k = 0; k < 15; k++) begin
      drive(k[0], 0, k[1], 8'h33);
      check(irq_n, 1'b0, "R8 sticky");
    end
    drive(0, 1, 1, 8'h00);
    check(irq_n, 1'b1, "R4 ack value 0");
    run_quiet(80, "R3 disabled no fire");

    // R7: zero with enable
    load(8'h00, 8'h80);
    run_quiet(100, "R7 zero load");

    // R5: gaps in cyc_en
    load(8'd40, 8'h80);
    for (int k = 0; k < 30; k++) begin
      drive(0, 0, 0, 8'h00);
      check(irq_n, 1'b1, "R5 no tick no count");
    end
    run_fire(40, 50, "R5 gated fire");

    // R3 reload mid-count, R1 low write during count
    load(8'd100, 8'h80);
    for (int k = 0; k < 30; k++) begin drive(0, 0, 1, 0); check(irq_n, 1'b1, "R2 before reload"); end
    drive(1, 0, 1, 8'd20);
    check(irq_n, 1'b1, "R1 low during count");
    drive(0, 1, 1, 8'h80);
    run_fire(20, 100, "R2 reload restarts");

    // R3 disable mid-count
    load(8'd50, 8'h80);
    for (int k = 0; k < 10; k++) begin drive(0, 0, 1, 0); check(irq_n, 1'b1, "R3 before stop"); end
    drive(0, 1, 1, 8'h00);
    run_quiet(100, "R3 disabled mid count");

    // R10: simultaneous strobes use old held byte
    drive(1, 0, 1, 8'd7);
    drive(1, 1, 1, 8'h80);
    check(irq_n, 1'b1, "R10 both strobes");
    run_fire(7, 100, "R10 old byte used");
    drive(0, 1, 1, 8'h80);
    run_fire(start_val(8'h80, 8'h80), 100, "R10 new byte held");

    // R6: after fire, ack without enable gives no second fire
    drive(0, 1, 1, 8'h00);
    run_quiet(50, "R6 one shot");

    // Random loads
    for (int i = 0; i < 20; i++) begin
      logic [7:0] lo;
      logic [7:0] hi;
      int n;
      int pct;
      lo  = 8'($urandom);
      hi  = {1'b1, 7'($urandom % 2)};
      n   = start_val(hi, lo);
      pct = 30 + int'($urandom % 71);
      load(lo, hi);
      if (n == 0) run_quiet(20, "R7 random zero");
      else        run_fire(n, pct, "R2 random");
    end

    // R2 maximum value
    load(8'hFF, 8'hFF);
    run_fire(32767, 100, "R2 max count");

    // R9: async reset while low, then cleared state
    @(negedge clk); rst_n = 1'b0; #1;
    check(irq_n, 1'b1, "R9 async release");
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    held = 8'h00;
    drive(0, 1, 1, 8'h80);
    run_quiet(60, "R9 count cleared");
    drive(0, 1, 1, 8'h81);
    run_fire(start_val(8'h81, held), 100, "R9 hold cleared");

    // R9: reset mid-count
    load(8'd30, 8'h80);
    for (int k = 0; k < 10; k++) begin drive(0, 0, 1, 0); check(irq_n, 1'b1, "R9 pre reset"); end
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    run_quiet(60, "R9 reset mid count");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule